// File: doc/BRIEF.md
# Serial Core Test Wrapper Registers

This block is the serial register layer of a core test wrapper placed between a chip-level test access mechanism and a diagnostic memory BIST engine. A test controller outside the block moves serial data from `wsi` to `wso` on the wrapper clock, using select, shift, capture and update strobes. A short instruction register picks which register sits in the serial path: a one-bit bypass, a command register, or a data register.

The command register holds a 3-bit BIST command. Updating it with the reset or start command sends a one-cycle pulse to the BIST engine. The data register works in either direction, depending on the held command. Under the step-load command it is an input, and its low bits become the BIST step budget on update. Under the three read commands it captures the completion flag, the last-error record (step and faulty word) or the error count. Unassigned command codes route the data path through the bypass bit.

Every parallel output changes only on an update strobe, so the BIST engine never sees a half-shifted value.

Top module: `core_test_wrapper`

## Requirements
- R1: While `wrstn` is low and after it rises, the instruction register selects bypass (code 00), the bypass bit is 0, so `wso` is 0. The held command is read-status (011), both command pulses and the load pulse are 0, and `step_budget` equals `DEFAULT_STEPS`.
- R2: When `select_wir` is high, the 2-bit instruction register shifts LSB first from `wsi` to `wso`. The new code takes effect on update. Code 00 selects bypass, 01 the command register, 10 the data register, and 11 bypass.
- R3: The bypass bit captures 0 and delays `wsi` by one shift cycle to `wso`.
- R4: An update of the command register with code 000 raises `bist_reset` for exactly the one cycle that follows the update edge. Code 001 does the same for `bist_start`. The two pulses are never high together.
- R5: Commands 010 to 101 raise neither command pulse. With code 110 or 111 held, the data-register path is replaced by the one-bit bypass.
- R6: With command 010 held, an update of the data register copies its low `STEP_W` bits to `step_budget` and raises `step_load` for one cycle.
- R7: An update of the data register under any other command leaves `step_budget` unchanged and `step_load` low.
- R8: Under command 011, capture loads `bist_done` into bit 0 of the data register and zeros into the rest.
- R9: Under command 100, capture loads the last error step into bits [STEP_W-1:0] and the faulty word into the next `WORD_W` bits. All higher bits are 0.
- R10: Under command 101, capture loads the error count into bits [CNT_W-1:0]. All higher bits are 0.
- R11: Shifting and capturing never change `step_budget` or the held command.
- R12: A capture of the command register loads the held command, so it can be shifted out, LSB first, without changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Wrapper clock |
| wrstn | input | 1 | Asynchronous reset, active low |
| wsi | input | 1 | Serial data in |
| wso | output | 1 | Serial data out (LSB of selected register) |
| select_wir | input | 1 | Selects the instruction register for the serial path |
| shift_wr | input | 1 | Shift strobe |
| capture_wr | input | 1 | Capture strobe |
| update_wr | input | 1 | Update strobe |
| bist_reset | output | 1 | One-cycle BIST reset command |
| bist_start | output | 1 | One-cycle BIST start command |
| step_load | output | 1 | One-cycle strobe with a new step budget |
| step_budget | output | STEP_W | Step budget held for the BIST |
| bist_done | input | 1 | BIST run finished (end reached or budget used) |
| err_count | input | CNT_W | Errors detected since BIST reset |
| last_err_step | input | STEP_W | Step index of the last error |
| last_err_word | input | WORD_W | Read word XOR expected word at the last error |

## Verification
The bench checks that a command pulse lands in the single cycle after the update edge. A design with an extra register would pulse one cycle late, and one that decodes the live shift register would pulse while bits are still moving. It reads the step budget after shifting a new value but before the update, which catches a budget that follows the shift chain. It packs the last-error step and word into a known pattern to expose swapped or misaligned fields. It selects an unassigned command code and expects a one-bit path, which a design that kept the full data register in the chain would fail.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CMD_W = 3;
  localparam int WIR_W = 2;

  localparam logic [CMD_W-1:0] CMD_RESET = 3'd0;
  localparam logic [CMD_W-1:0] CMD_RUN   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_LOAD  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_STAT  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_RES   = 3'd4;
  localparam logic [CMD_W-1:0] CMD_ERR   = 3'd5;

  localparam logic [WIR_W-1:0] WIR_BYP = 2'd0;
  localparam logic [WIR_W-1:0] WIR_CTL = 2'd1;
  localparam logic [WIR_W-1:0] WIR_DAT = 2'd2;

  // True for the six assigned command codes
  function automatic logic cmd_known(input logic [CMD_W-1:0] c);
    return c <= CMD_ERR;
  endfunction
endpackage

// File: rtl/cw_instr_reg.sv
module cw_instr_reg
  import cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             shift,
  input  logic             capture,
  input  logic             update,
  input  logic             si,
  output logic             so,
  output logic [WIR_W-1:0] code
);
  logic [WIR_W-1:0] sh_q;
  logic             wir_upd_ev;

  assign wir_upd_ev = sel && update && !shift && !capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      code <= WIR_BYP;
    end else begin
      if (sel && capture)    sh_q <= code;
      else if (sel && shift) sh_q <= {si, sh_q[WIR_W-1:1]};
      if (wir_upd_ev)        code <= sh_q;
    end
  end

  assign so = sh_q[0];

  // R2
  wir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wir_upd_ev |=> $stable(code));
endmodule

// File: rtl/cw_ctrl_reg.sv
module cw_ctrl_reg
  import cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             shift,
  input  logic             capture,
  input  logic             update,
  input  logic             si,
  output logic             so,
  output logic [CMD_W-1:0] cmd,
  output logic             rst_pulse,
  output logic             run_pulse
);
  logic [CMD_W-1:0] sh_q;
  logic             cmd_upd_ev;

  assign cmd_upd_ev = en && update && !shift && !capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cmd       <= CMD_STAT;
      rst_pulse <= 1'b0;
      run_pulse <= 1'b0;
    end else begin
      if (en && capture)    sh_q <= cmd;
      else if (en && shift) sh_q <= {si, sh_q[CMD_W-1:1]};
      if (cmd_upd_ev) cmd <= sh_q;
      rst_pulse <= cmd_upd_ev && (sh_q == CMD_RESET);
      run_pulse <= cmd_upd_ev && (sh_q == CMD_RUN);
    end
  end

  assign so = sh_q[0];

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_pulse, run_pulse}));
  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse || run_pulse) |-> $past(cmd_upd_ev));
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_upd_ev |=> $stable(cmd));
endmodule

// File: rtl/cw_data_reg.sv
module cw_data_reg
  import cw_pkg::*;
#(
  parameter int STEP_W        = 12,
  parameter int WORD_W        = 8,
  parameter int CNT_W         = 10,
  parameter int DEFAULT_STEPS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              shift,
  input  logic              capture,
  input  logic              update,
  input  logic              si,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              done,
  input  logic [CNT_W-1:0]  count,
  input  logic [STEP_W-1:0] last_step,
  input  logic [WORD_W-1:0] last_word,
  output logic              so,
  output logic [STEP_W-1:0] budget,
  output logic              load_pulse
);
  localparam int REC_W  = STEP_W + WORD_W;
  localparam int DATA_W = (REC_W > CNT_W) ? REC_W : CNT_W;

  function automatic logic [DATA_W-1:0] capture_word(
    input logic [CMD_W-1:0]  c,
    input logic              d,
    input logic [CNT_W-1:0]  n,
    input logic [STEP_W-1:0] s,
    input logic [WORD_W-1:0] w,
    input logic [DATA_W-1:0] cur
  );
    logic [DATA_W-1:0] v;
    v = '0;
    case (c)
      CMD_STAT: v[0] = d;
      CMD_RES: begin
        v[STEP_W-1:0]      = s;
        v[STEP_W +: WORD_W] = w;
      end
      CMD_ERR: v[CNT_W-1:0] = n;
      default: v = cur;
    endcase
    return v;
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic              dat_upd_ev;
  logic              load_ev;

  assign dat_upd_ev = en && update && !shift && !capture;
  assign load_ev    = dat_upd_ev && (cmd == CMD_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      budget     <= STEP_W'(DEFAULT_STEPS);
      load_pulse <= 1'b0;
    end else begin
      if (en && capture)
        sh_q <= capture_word(cmd, done, count, last_step, last_word, sh_q);
      else if (en && shift)
        sh_q <= {si, sh_q[DATA_W-1:1]};
      if (load_ev) budget <= sh_q[STEP_W-1:0];
      load_pulse <= load_ev;
    end
  end

  assign so = sh_q[0];

  // R7
  budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(budget) |-> load_pulse);
  // R6
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> ($past(cmd) == CMD_LOAD));
  // R11
  shift_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift || capture) |=> $stable(budget));
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import cw_pkg::*;
#(
  parameter int STEP_W        = 12,
  parameter int WORD_W        = 8,
  parameter int CNT_W         = 10,
  parameter int DEFAULT_STEPS = 48
) (
  input  logic              wrck,
  input  logic              wrstn,
  input  logic              wsi,
  output logic              wso,
  input  logic              select_wir,
  input  logic              shift_wr,
  input  logic              capture_wr,
  input  logic              update_wr,
  output logic              bist_reset,
  output logic              bist_start,
  output logic              step_load,
  output logic [STEP_W-1:0] step_budget,
  input  logic              bist_done,
  input  logic [CNT_W-1:0]  err_count,
  input  logic [STEP_W-1:0] last_err_step,
  input  logic [WORD_W-1:0] last_err_word
);
  logic [WIR_W-1:0] wir_code;
  logic [CMD_W-1:0] cmd;
  logic             wir_so, ctl_so, dat_so;
  logic             ctl_en, dat_en, byp_en;
  logic             byp_q, byp_cap_ev;

  assign ctl_en = !select_wir && (wir_code == WIR_CTL);
  assign dat_en = !select_wir && (wir_code == WIR_DAT) && cmd_known(cmd);
  assign byp_en = !select_wir && !ctl_en && !dat_en;
  assign byp_cap_ev = byp_en && capture_wr;

  cw_instr_reg u_wir (
    .clk(wrck), .rst_n(wrstn), .sel(select_wir), .shift(shift_wr),
    .capture(capture_wr), .update(update_wr), .si(wsi),
    .so(wir_so), .code(wir_code)
  );

  cw_ctrl_reg u_ctl (
    .clk(wrck), .rst_n(wrstn), .en(ctl_en), .shift(shift_wr),
    .capture(capture_wr), .update(update_wr), .si(wsi),
    .so(ctl_so), .cmd(cmd), .rst_pulse(bist_reset), .run_pulse(bist_start)
  );

  cw_data_reg #(
    .STEP_W(STEP_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .DEFAULT_STEPS(DEFAULT_STEPS)
  ) u_dat (
    .clk(wrck), .rst_n(wrstn), .en(dat_en), .shift(shift_wr),
    .capture(capture_wr), .update(update_wr), .si(wsi), .cmd(cmd),
    .done(bist_done), .count(err_count), .last_step(last_err_step),
    .last_word(last_err_word), .so(dat_so), .budget(step_budget),
    .load_pulse(step_load)
  );

  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn)                     byp_q <= 1'b0;
    else if (byp_cap_ev)            byp_q <= 1'b0;
    else if (byp_en && shift_wr)    byp_q <= wsi;
  end

  always_comb begin
    if (select_wir)  wso = wir_so;
    else if (ctl_en) wso = ctl_so;
    else if (dat_en) wso = dat_so;
    else             wso = byp_q;
  end

  // R3
  byp_cap_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    byp_cap_ev |=> !byp_q);
  // R4
  pulse_load_excl_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    $onehot0({bist_reset, bist_start, step_load}));
endmodule

// File: tb/tb_core_test_wrapper.sv
module tb_core_test_wrapper;
  localparam int STEP_W = 12, WORD_W = 8, CNT_W = 10, DEF = 48;
  localparam int DATA_W = 20;

  logic clk = 0, rstn = 0, wsi = 0, sel = 0, sh = 0, cap = 0, upd = 0;
  logic wso, b_rst, b_run, s_load, done = 0;
  logic [STEP_W-1:0] budget, lstep = '0;
  logic [CNT_W-1:0]  cnt = '0;
  logic [WORD_W-1:0] lword = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  core_test_wrapper #(.STEP_W(STEP_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .DEFAULT_STEPS(DEF)) dut (
    .wrck(clk), .wrstn(rstn), .wsi(wsi), .wso(wso), .select_wir(sel),
    .shift_wr(sh), .capture_wr(cap), .update_wr(upd), .bist_reset(b_rst),
    .bist_start(b_run), .step_load(s_load), .step_budget(budget),
    .bist_done(done), .err_count(cnt), .last_err_step(lstep),
    .last_err_word(lword));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [31:0] din, input int n, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sh = 1; wsi = din[i];
      #1 dout[i] = wso;
    end
    @(negedge clk); sh = 0; wsi = 0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1;
    @(negedge clk); upd = 0;
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap = 1;
    @(negedge clk); cap = 0;
  endtask

  task automatic set_wir(input logic [1:0] code);
    logic [31:0] d;
    @(negedge clk); sel = 1;
    scan({30'd0, code}, 2, d);
    pulse_upd();
    @(negedge clk); sel = 0;
  endtask

  task automatic set_cmd(input logic [2:0] c);
    logic [31:0] d;
    set_wir(2'b01);
    scan({29'd0, c}, 3, d);
    pulse_upd();
  endtask

  task automatic t_reset();
    check("R1 wso", wso, 0);
    check("R1 budget", budget, DEF);
    check("R1 pulses", {b_rst, b_run, s_load}, 0);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    pulse_cap();
    scan(32'b1101, 4, d);
    check("R3 bypass path", d[3:0], 4'b1010);
  endtask

  task automatic t_cmds();
    logic [31:0] d;
    set_wir(2'b01);
    pulse_cap();
    scan(32'd3, 3, d);
    check("R12 ctrl readback reset cmd", d[2:0], 3'b011);
    set_cmd(3'b001);
    check("R4 start pulse", {b_run, b_rst}, 2'b10);
    @(negedge clk);
    check("R4 start one cycle", b_run, 0);
    set_cmd(3'b000);
    check("R4 reset pulse", {b_rst, b_run}, 2'b10);
    @(negedge clk);
    check("R4 reset one cycle", b_rst, 0);
    pulse_cap();
    scan(32'd5, 3, d);
    check("R12 ctrl readback", d[2:0], 3'b000);
    set_cmd(3'b100);
    check("R5 no pulse on 100", {b_rst, b_run}, 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    set_cmd(3'b010);
    check("R5 no pulse on 010", {b_rst, b_run}, 0);
    set_wir(2'b10);
    scan(32'h000A5, DATA_W, d);
    check("R11 budget held during shift", budget, DEF);
    pulse_upd();
    check("R6 budget loaded", budget, 12'h0A5);
    check("R6 load pulse", s_load, 1);
    @(negedge clk);
    check("R6 load one cycle", s_load, 0);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    set_cmd(3'b011);
    set_wir(2'b10);
    done = 1; pulse_cap();
    scan(32'h00777, DATA_W, d);
    check("R8 status done", d[DATA_W-1:0], 1);
    pulse_upd();
    check("R7 budget kept", budget, 12'h0A5);
    check("R7 no load", s_load, 0);
    done = 0; pulse_cap();
    scan(32'h0, DATA_W, d);
    check("R8 status busy", d[DATA_W-1:0], 0);
    set_cmd(3'b100);
    set_wir(2'b10);
    lstep = 12'h321; lword = 8'h5C; pulse_cap();
    scan(32'h0, DATA_W, d);
    check("R9 last error record", d[DATA_W-1:0], 20'h5C321);
    set_cmd(3'b101);
    set_wir(2'b10);
    cnt = 10'h2AB; pulse_cap();
    scan(32'h0, DATA_W, d);
    check("R10 error count", d[DATA_W-1:0], 20'h002AB);
  endtask

  task automatic t_unassigned();
    logic [31:0] d;
    set_cmd(3'b110);
    check("R5 no pulse on 110", {b_rst, b_run}, 0);
    set_wir(2'b10);
    pulse_cap();
    scan(32'b101, 3, d);
    check("R5 bypass on 110", d[2:0], 3'b010);
    pulse_upd();
    check("R7 budget kept on 110", budget, 12'h0A5);
  endtask

  task automatic t_wir11();
    logic [31:0] d;
    set_wir(2'b11);
    pulse_cap();
    scan(32'b011, 3, d);
    check("R2 code 11 bypass", d[2:0], 3'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstn = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_cmds();
    t_load();
    t_reads();
    t_unassigned();
    t_wir11();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule